// File: doc/BRIEF.md
# Correctable Link Error Status and Mask Registers

This block holds two 32-bit configuration words for a link port. The first is a status word that records correctable link-level error events. The second is a mask word that decides, bit by bit, whether an event is reported upstream.

Six error sources feed the block as single-cycle pulses from the physical and data link layers:
- receiver error
- bad transaction packet
- bad link packet
- replay-number rollover
- replay timer expiry
- advisory non-fatal

Every event is logged in its status bit, whether it is masked or not. An unmasked event also produces a one-cycle `err_report` pulse toward the root. Software reads both words through a simple register port that has a byte address, read and write strobes, and byte lane enables. It clears a logged status bit by writing a one to that bit.

Status and mask bits are sticky. A hot or warm link reset leaves them alone and only quiets the block's outputs. Only the power-on reset returns them to zero. The logging state therefore survives the link recovery that usually follows such errors.

Top module: `cerr_status_mask`

## Requirements
- R1: After the power-on reset (`por_n` low) every status and mask bit is 0, both words read as 0, and `err_report` is 0.
- R2: The status word sits at byte address 0x110 and the mask word at 0x114, both compared over the full 12-bit address. A read of any other address returns 0, and a write to it changes nothing.
- R3: Event input bit k maps to register bit position 0, 6, 7, 8, 12, 13 for k = 0..5, and this holds in both words. All other bit positions read as 0, and writes to them are ignored.
- R4: A pulse on `evt_i[k]` sets status bit k from the next cycle on. Writing a 1 to that bit position clears it, writing a 0 leaves it unchanged, and `cfg_be[n]` gates register bits 8n+7..8n of a write.
- R5: When an event and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R6: Mask bits are read/write at the same positions as their status bits, bit 13 included. A masked event still sets its status bit.
- R7: `err_report` is 1 for exactly the cycle after any cycle in which some unmasked event arrives. This holds even when the status bit is already set, and several events in one cycle give one pulse. Otherwise `err_report` is 0.
- R8: While `link_rst_n` is low, `err_report` and `cfg_rdata` are 0. Status and mask bits keep their values, and events are still logged.
- R9: `cfg_rdata` carries the addressed word in the cycle after a `cfg_rd` cycle and is 0 in every other cycle. A read has no side effect. A read in the same cycle as a write returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears everything |
| link_rst_n | input | 1 | Hot/warm link reset, active low; clears outputs only |
| evt_i | input | 6 | Error event pulses: 0 receiver, 1 bad packet, 2 bad link packet, 3 replay rollover, 4 replay timeout, 5 advisory non-fatal |
| cfg_addr | input | 12 | Byte address of the access |
| cfg_wr | input | 1 | Write strobe |
| cfg_rd | input | 1 | Read strobe |
| cfg_be | input | 4 | Byte lane enables for writes |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, valid the cycle after `cfg_rd` |
| err_report | output | 1 | One-cycle pulse requesting a correctable error report |

## Verification
The assertions check the following on every cycle:
- Each status bit's set, hold and clear rules, including the event-over-clear race.
- The reporting rule tying `err_report` to the previous cycle's unmasked events.
- Reserved positions always reading zero.
- Both outputs staying quiet during a link reset.

The following can only be shown by the bench's scenarios, which read the words back through the register port:
- The address decode and the byte lane gating of writes.
- That mask bits, bit 13 among them, hold what was written.
- That the logged state is still there once a link reset ends.
- That a second power-on reset clears it all.

// File: rtl/cerr_pkg.sv
package cerr_pkg;

    localparam int NUM_EVT = 6;
    localparam int REG_W   = 32;
    localparam int LANES   = REG_W / 8;

    typedef enum logic [0:0] {
        BANK_W1C = 1'b0,
        BANK_RW  = 1'b1
    } bank_mode_e;

    // register bit position of each event source; the order is fixed
    function automatic int evt_pos(input int k);
        case (k)
            0:       return 0;
            1:       return 6;
            2:       return 7;
            3:       return 8;
            4:       return 12;
            5:       return 13;
            default: return 0;
        endcase
    endfunction

    function automatic logic [REG_W-1:0] field_mask();
        logic [REG_W-1:0] m;
        m = '0;
        for (int k = 0; k < NUM_EVT; k++) begin
            m[evt_pos(k)] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [REG_W-1:0] spread(input logic [NUM_EVT-1:0] v);
        logic [REG_W-1:0] w;
        w = '0;
        for (int k = 0; k < NUM_EVT; k++) begin
            w[evt_pos(k)] = v[k];
        end
        return w;
    endfunction

    typedef struct packed {
        logic [NUM_EVT-1:0] bits;
    } bank_state_t;

    typedef struct packed {
        logic [REG_W-1:0] rdata;
    } port_state_t;

    typedef struct packed {
        logic pulse;
    } rpt_state_t;

endpackage

// File: rtl/cerr_sticky_bank.sv
module cerr_sticky_bank
    import cerr_pkg::*;
#(
    parameter int         N    = NUM_EVT,
    parameter bank_mode_e MODE = BANK_W1C
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic [N-1:0] wen_i,
    input  logic [N-1:0] wval_i,
    output logic [N-1:0] bits_o
);

    typedef struct packed {
        logic [N-1:0] bits;
    } st_t;

    st_t          st_d, st_q;
    logic [N-1:0] nxt;

    generate
        if (MODE == BANK_W1C) begin : g_w1c
            logic unused_rw;
            assign unused_rw = ^{wen_i, wval_i};
            for (genvar k = 0; k < N; k++) begin : g_bit
                // an arriving event outranks a same-cycle clear
                assign nxt[k] = set_i[k] | (st_q.bits[k] & ~clr_i[k]);
            end
        end else begin : g_rw
            logic unused_w1c;
            assign unused_w1c = ^{set_i, clr_i};
            for (genvar k = 0; k < N; k++) begin : g_bit
                assign nxt[k] = wen_i[k] ? wval_i[k] : st_q.bits[k];
            end
        end
    endgenerate

    always_comb begin
        st_d      = st_q;
        st_d.bits = nxt;
    end

    // only the power-on reset reaches these flops: sticky storage
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bits_o = st_q.bits;

endmodule

// File: rtl/cerr_cfg_port.sv
module cerr_cfg_port
    import cerr_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int STATUS_OFS = 'h110,
    parameter int MASK_OFS   = 'h114
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               wr_i,
    input  logic               rd_i,
    input  logic [LANES-1:0]   be_i,
    input  logic [REG_W-1:0]   wdata_i,
    input  logic [NUM_EVT-1:0] status_i,
    input  logic [NUM_EVT-1:0] mask_i,
    output logic [NUM_EVT-1:0] stat_clr_o,
    output logic [NUM_EVT-1:0] mask_wen_o,
    output logic [NUM_EVT-1:0] mask_wval_o,
    output logic [REG_W-1:0]   rdata_o
);

    localparam logic [ADDR_W-1:0] ST_ADDR = ADDR_W'(STATUS_OFS);
    localparam logic [ADDR_W-1:0] MK_ADDR = ADDR_W'(MASK_OFS);
    localparam logic [REG_W-1:0]  FIELDS  = field_mask();

    logic hit_st, hit_mk;
    logic unused_wdata;

    port_state_t      st_d, st_q;
    logic [REG_W-1:0] word_st, word_mk;

    assign hit_st       = (addr_i == ST_ADDR);
    assign hit_mk       = (addr_i == MK_ADDR);
    assign unused_wdata = ^(wdata_i & ~FIELDS);

    generate
        for (genvar k = 0; k < NUM_EVT; k++) begin : g_field
            localparam int P    = evt_pos(k);
            localparam int LANE = P / 8;
            assign stat_clr_o[k]  = wr_i & hit_st & be_i[LANE] & wdata_i[P];
            assign mask_wen_o[k]  = wr_i & hit_mk & be_i[LANE];
            assign mask_wval_o[k] = wdata_i[P];
        end
    endgenerate

    assign word_st = spread(status_i);
    assign word_mk = spread(mask_i);

    always_comb begin
        st_d       = st_q;
        st_d.rdata = '0;
        if (rd_i) begin
            if (hit_st) begin
                st_d.rdata = word_st;
            end else if (hit_mk) begin
                st_d.rdata = word_mk;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata_o = st_q.rdata;

endmodule

// File: rtl/cerr_report.sv
module cerr_report
    import cerr_pkg::*;
#(
    parameter int N = NUM_EVT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_i,
    input  logic [N-1:0] mask_i,
    output logic         report_o
);

    rpt_state_t   st_d, st_q;
    logic [N-1:0] live;

    generate
        for (genvar k = 0; k < N; k++) begin : g_live
            assign live[k] = evt_i[k] & ~mask_i[k];
        end
    endgenerate

    always_comb begin
        st_d       = st_q;
        st_d.pulse = |live;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign report_o = st_q.pulse;

endmodule

// File: rtl/cerr_status_mask.sv
module cerr_status_mask
    import cerr_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int STATUS_OFS = 'h110,
    parameter int MASK_OFS   = 'h114
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               link_rst_n,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic               cfg_wr,
    input  logic               cfg_rd,
    input  logic [LANES-1:0]   cfg_be,
    input  logic [REG_W-1:0]   cfg_wdata,
    output logic [REG_W-1:0]   cfg_rdata,
    output logic               err_report
);

    logic               port_rst_n;
    logic [NUM_EVT-1:0] status_q;
    logic [NUM_EVT-1:0] mask_q;
    logic [NUM_EVT-1:0] stat_clr;
    logic [NUM_EVT-1:0] mask_wen;
    logic [NUM_EVT-1:0] mask_wval;

    // outputs fall back to zero on either reset, storage only on power-on
    assign port_rst_n = por_n & link_rst_n;

    cerr_sticky_bank #(
        .N    (NUM_EVT),
        .MODE (BANK_W1C)
    ) u_status (
        .clk    (clk),
        .por_n  (por_n),
        .set_i  (evt_i),
        .clr_i  (stat_clr),
        .wen_i  ('0),
        .wval_i ('0),
        .bits_o (status_q)
    );

    cerr_sticky_bank #(
        .N    (NUM_EVT),
        .MODE (BANK_RW)
    ) u_mask (
        .clk    (clk),
        .por_n  (por_n),
        .set_i  ('0),
        .clr_i  ('0),
        .wen_i  (mask_wen),
        .wval_i (mask_wval),
        .bits_o (mask_q)
    );

    cerr_cfg_port #(
        .ADDR_W     (ADDR_W),
        .STATUS_OFS (STATUS_OFS),
        .MASK_OFS   (MASK_OFS)
    ) u_port (
        .clk         (clk),
        .rst_n       (port_rst_n),
        .addr_i      (cfg_addr),
        .wr_i        (cfg_wr),
        .rd_i        (cfg_rd),
        .be_i        (cfg_be),
        .wdata_i     (cfg_wdata),
        .status_i    (status_q),
        .mask_i      (mask_q),
        .stat_clr_o  (stat_clr),
        .mask_wen_o  (mask_wen),
        .mask_wval_o (mask_wval),
        .rdata_o     (cfg_rdata)
    );

    cerr_report #(
        .N (NUM_EVT)
    ) u_report (
        .clk      (clk),
        .rst_n    (port_rst_n),
        .evt_i    (evt_i),
        .mask_i   (mask_q),
        .report_o (err_report)
    );

endmodule

// File: rtl/cerr_status_mask_chk.sv
module cerr_status_mask_chk
    import cerr_pkg::*;
(
    input logic               clk,
    input logic               por_n,
    input logic               link_rst_n,
    input logic [NUM_EVT-1:0] evt_i,
    input logic [NUM_EVT-1:0] status_q,
    input logic [NUM_EVT-1:0] mask_q,
    input logic [NUM_EVT-1:0] stat_clr,
    input logic [REG_W-1:0]   cfg_rdata,
    input logic               err_report
);

    localparam logic [REG_W-1:0] FIELDS = field_mask();

    AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!por_n)
        (cfg_rdata & ~FIELDS) == '0); // R3

    AST_REPORT_ON_UNMASKED: assert property (@(posedge clk) disable iff (!por_n || !link_rst_n)
        (|(evt_i & ~mask_q)) |=> err_report); // R7

    AST_NO_SPURIOUS_REPORT: assert property (@(posedge clk) disable iff (!por_n || !link_rst_n)
        !(|(evt_i & ~mask_q)) |=> !err_report); // R7

    AST_LINK_RST_QUIET: assert property (@(posedge clk) disable iff (!por_n)
        !link_rst_n |-> (!err_report && cfg_rdata == '0)); // R8

    generate
        for (genvar k = 0; k < NUM_EVT; k++) begin : g_bit
            AST_EVENT_LOGS: assert property (@(posedge clk) disable iff (!por_n)
                evt_i[k] |=> status_q[k]); // R4

            AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!por_n)
                (evt_i[k] && stat_clr[k]) |=> status_q[k]); // R5

            AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!por_n)
                (status_q[k] && !stat_clr[k]) |=> status_q[k]); // R8

            AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!por_n)
                (stat_clr[k] && !evt_i[k]) |=> !status_q[k]); // R4

            AST_NO_SELF_SET: assert property (@(posedge clk) disable iff (!por_n)
                (!status_q[k] && !evt_i[k]) |=> !status_q[k]); // R4
        end
    endgenerate

endmodule

bind cerr_status_mask cerr_status_mask_chk u_chk (
    .clk        (clk),
    .por_n      (por_n),
    .link_rst_n (link_rst_n),
    .evt_i      (evt_i),
    .status_q   (status_q),
    .mask_q     (mask_q),
    .stat_clr   (stat_clr),
    .cfg_rdata  (cfg_rdata),
    .err_report (err_report)
);

// File: tb/tb_cerr_status_mask.sv
module tb_cerr_status_mask;
    import cerr_pkg::*;

    localparam logic [11:0] A_ST = 12'h110;
    localparam logic [11:0] A_MK = 12'h114;

    logic               clk = 1'b0;
    logic               por_n = 1'b0;
    logic               link_rst_n = 1'b1;
    logic [NUM_EVT-1:0] evt_i = '0;
    logic [11:0]        cfg_addr = '0;
    logic               cfg_wr = 1'b0;
    logic               cfg_rd = 1'b0;
    logic [3:0]         cfg_be = '0;
    logic [31:0]        cfg_wdata = '0;
    logic [31:0]        cfg_rdata;
    logic               err_report;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    logic [NUM_EVT-1:0] m_st = '0;
    logic [NUM_EVT-1:0] m_mk = '0;

    always #4 clk = ~clk;

    cerr_status_mask dut (
        .clk        (clk),
        .por_n      (por_n),
        .link_rst_n (link_rst_n),
        .evt_i      (evt_i),
        .cfg_addr   (cfg_addr),
        .cfg_wr     (cfg_wr),
        .cfg_rd     (cfg_rd),
        .cfg_be     (cfg_be),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .err_report (err_report)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] m_read(input logic [11:0] a);
        if (a == A_ST) return spread(m_st);
        if (a == A_MK) return spread(m_mk);
        return 32'h0;
    endfunction

    // one clock: drive at negedge, model, compare at the next negedge
    task automatic cyc(input logic [5:0] ev, input logic wr, input logic rd,
                       input logic [11:0] a, input logic [3:0] be,
                       input logic [31:0] wd, input string req);
        logic        e_rpt;
        logic [31:0] e_rd;
        evt_i = ev; cfg_wr = wr; cfg_rd = rd; cfg_addr = a; cfg_be = be; cfg_wdata = wd;
        e_rpt = |(ev & ~m_mk);
        e_rd  = rd ? m_read(a) : 32'h0;
        for (int k = 0; k < NUM_EVT; k++) begin
            int p = evt_pos(k);
            logic ln = be[p/8];
            logic clr = wr && (a == A_ST) && ln && wd[p];
            m_st[k] = ev[k] | (m_st[k] & ~clr);
            if (wr && (a == A_MK) && ln) m_mk[k] = wd[p];
        end
        @(posedge clk);
        @(negedge clk);
        chk({req, " report (R7)"}, {31'h0, err_report}, {31'h0, e_rpt});
        chk({req, " rdata (R9)"}, cfg_rdata, e_rd);
        evt_i = '0; cfg_wr = 1'b0; cfg_rd = 1'b0;
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string req);
        cyc('0, 1'b0, 1'b1, a, 4'h0, 32'h0, req);
        chk(req, cfg_rdata, exp);
    endtask

    task automatic power_on();
        por_n = 1'b0;
        m_st = '0; m_mk = '0;
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        power_on();
        // R1 reset state
        chk("R1 report after reset", {31'h0, err_report}, 32'h0);
        rd_chk(A_ST, 32'h0, "R1 status after reset");
        rd_chk(A_MK, 32'h0, "R1 mask after reset");

        // R3 R6 all-ones into mask: only the six fields stick, bit 13 included
        cyc('0, 1'b1, 1'b0, A_MK, 4'hF, 32'hFFFF_FFFF, "R6 mask write");
        rd_chk(A_MK, 32'h0000_31C1, "R3 R6 mask fields");
        cyc('0, 1'b1, 1'b0, A_MK, 4'hF, 32'h0, "R6 mask clear");
        rd_chk(A_MK, 32'h0, "R6 mask zero");

        // R4 log every source, write-0 keeps, lane-gated write-1 clears
        cyc(6'h3F, 1'b0, 1'b0, A_ST, 4'h0, 32'h0, "R4 all events");
        rd_chk(A_ST, 32'h0000_31C1, "R4 all logged");
        cyc('0, 1'b1, 1'b0, A_ST, 4'hF, 32'h0, "R4 write zero");
        rd_chk(A_ST, 32'h0000_31C1, "R4 write zero keeps");
        cyc('0, 1'b1, 1'b0, A_ST, 4'h1, 32'hFFFF_FFFF, "R4 lane0 clear");
        rd_chk(A_ST, 32'h0000_3100, "R4 lane gating");

        // R5 event and clear on bit 12 together
        cyc(6'h10, 1'b1, 1'b0, A_ST, 4'hF, 32'h0000_1000, "R5 race");
        rd_chk(A_ST, 32'h0000_3100, "R5 event wins");

        // R9 read with write same cycle returns old value
        cyc('0, 1'b1, 1'b1, A_ST, 4'hF, 32'h0000_2000, "R9 rd+wr");
        chk("R9 old value on rd+wr", cfg_rdata, 32'h0000_3100);
        rd_chk(A_ST, 32'h0000_1100, "R9 write applied");

        // R6 masked event logged without report; R7 repeat on set bit
        cyc('0, 1'b1, 1'b0, A_MK, 4'hF, 32'h0000_0001, "R6 mask rx");
        cyc(6'h01, 1'b0, 1'b0, A_ST, 4'h0, 32'h0, "R6 masked event");
        chk("R6 no report when masked", {31'h0, err_report}, 32'h0);
        rd_chk(A_ST, 32'h0000_1101, "R6 masked still logged");
        cyc(6'h08, 1'b0, 1'b0, A_ST, 4'h0, 32'h0, "R7 repeat set bit");
        chk("R7 pulse on already set", {31'h0, err_report}, 32'h1);
        cyc('0, 1'b0, 1'b0, A_ST, 4'h0, 32'h0, "R7 one cycle");
        chk("R7 pulse ends", {31'h0, err_report}, 32'h0);

        // R2 other offsets
        cyc('0, 1'b1, 1'b0, 12'h118, 4'hF, 32'hFFFF_FFFF, "R2 stray write");
        rd_chk(12'h118, 32'h0, "R2 stray read");
        rd_chk(12'h111, 32'h0, "R2 unaligned read");
        rd_chk(A_MK, 32'h0000_0001, "R2 mask untouched");

        // R8 link reset keeps state, quiets outputs, still logs
        link_rst_n = 1'b0;
        evt_i = 6'h20;
        m_st[5] = 1'b1;
        @(negedge clk);
        evt_i = '0;
        @(negedge clk);
        chk("R8 report quiet", {31'h0, err_report}, 32'h0);
        chk("R8 rdata quiet", cfg_rdata, 32'h0);
        link_rst_n = 1'b1;
        @(negedge clk);
        rd_chk(A_ST, 32'h0000_3101, "R8 status kept");
        rd_chk(A_MK, 32'h0000_0001, "R8 mask kept");

        // constrained random traffic
        for (int i = 0; i < 3000; i++) begin
            logic [5:0]  ev;
            logic [11:0] a;
            logic [31:0] wd;
            int          r;
            ev = (($urandom % 4) == 0) ? 6'($urandom) : 6'h0;
            r  = $urandom % 8;
            a  = (r < 3) ? A_ST : (r < 6) ? A_MK : 12'($urandom);
            wd = $urandom;
            cyc(ev, ($urandom % 3) == 0, ($urandom % 2) == 0, a, 4'($urandom), wd, "R4 R6 random");
        end

        // R1 second power-on clears sticky state
        power_on();
        rd_chk(A_ST, 32'h0, "R1 status after second reset");
        rd_chk(A_MK, 32'h0, "R1 mask after second reset");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule